// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block connects an internal valid/ready request port to an external asynchronous static RAM of 262,144 words by 16 bits. Each request carries a read or write flag, an 18-bit word address, 16 bits of write data and a two-bit lane mask. The controller then runs one fully timed access on the RAM pins. Those pins are active-low chip, output and write enables, one active-low enable per byte lane, the address, and a split data bus. The split bus has an outgoing word, a drive enable that feeds the pad tristate, and an incoming word.

Every phase length is derived from a nanosecond figure and the clock period parameter `CLK_PERIOD_NS`. The figure is divided by the period, rounded up, with a floor of one cycle. The control is a five-state machine:

- `ST_IDLE`: all strobes high, ready asserted.
- `ST_RD_ACCESS`: chip and output enables low for the access time.
- `ST_RD_RELEASE`: all strobes high while the RAM lets go of the bus.
- `ST_WR_STROBE`: chip and write enables low with the data bus driven.
- `ST_WR_HOLD`: one cycle with strobes high and the data still driven.

The transitions are:

- accept read: `ST_IDLE` to `ST_RD_ACCESS`.
- access done: `ST_RD_ACCESS` to `ST_RD_RELEASE`.
- released: `ST_RD_RELEASE` to `ST_IDLE`.
- accept write: `ST_IDLE` to `ST_WR_STROBE`.
- pulse done: `ST_WR_STROBE` to `ST_WR_HOLD`.
- hold done: `ST_WR_HOLD` to `ST_IDLE`.

A one-cycle `rsp_valid` reports the end of each access; for reads it carries the data.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are 1, `mem_dq_drive` is 0 and `req_ready` is 1.
- R2: An accepted read holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and the request address for RD_LEN cycles. RD_LEN is the largest of ceil(55/P), ceil(30/P) and ceil(55/P), where P = `CLK_PERIOD_NS`, giving 7 at P=8. Bit 0 of `mem_be_n` (bits 7:0) is low when mask bit 0 is 1, and bit 1 (bits 15:8) is low when mask bit 1 is 1.
- R3: Read data is sampled from `mem_dq_in` on the last access cycle. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the first cycle after the access. Lanes whose mask bit is 0 read as zero.
- R4: After every read, all strobes are 1 and `mem_dq_drive` is 0 for ceil(20/P) cycles (3 at P=8) before the block returns to idle. The bus drive never rises fewer than that many cycles after `mem_oe_n` was last low.
- R5: An accepted write holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1, the address and `mem_dq_drive`=1 with the write data for WR_LEN cycles, with lanes per the R2 mask encoding. WR_LEN is the largest of ceil(40/P), ceil(50/P), ceil(25/P) and ceil(55/P)-1, giving 7 at P=8.
- R6: After the write pulse comes one hold cycle. In it all strobes are 1, the data is still driven and unchanged, and `rsp_valid` is 1.
- R7: `req_ready` is 1 only in idle. A request held valid while an access runs is taken only once the block is idle again, so back-to-back requests each get a complete cycle.
- R8: `mem_dq_drive` is never 1 while `mem_oe_n` is 0, and `mem_we_n` is never 0 while `mem_oe_n` is 0.
- R9: With mask 00 the full cycle still runs, but both byte enables stay 1. No memory byte changes and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | 2 | RAM byte enables, active low, bit 0 = lower lane |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_drive | output | 1 | Tristate enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
Two functions can coincide in one cycle. A read's done strobe and release wait can overlap a new request that is already being held valid, and that request may be a write whose bus drive must not start during the release. The bench keeps `req_valid` high from the cycle a request is taken, chaining read, write and read back to back. Its cycle model then expects `req_ready` low through the whole release and the drive to rise only in the first write-strobe cycle after a further idle cycle. The bench's RAM model returns garbage until 55 ns of access have elapsed and checks pulse and data-setup widths at every write end, so a shortened phase shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_STROBE,
        ST_WR_HOLD
    } ctrl_state_e;

    // Round a nanosecond requirement up to whole clock cycles, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          lane_sel,
    input  logic                      strobe_on,
    output logic [LANES-1:0]          lane_en_n,
    input  logic [LANES*LANE_W-1:0]   bus_in,
    input  logic                      capture,
    output logic [LANES*LANE_W-1:0]   captured
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_n[g] = !(strobe_on && lane_sel[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                captured[g*LANE_W +: LANE_W] <= '0;
            else if (capture)
                captured[g*LANE_W +: LANE_W] <= lane_sel[g] ? bus_in[g*LANE_W +: LANE_W]
                                                            : '0;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned T_READ_CYC    = 55,
    parameter int unsigned T_ADDR_ACC    = 55,
    parameter int unsigned T_OE_ACC      = 30,
    parameter int unsigned T_BUS_REL     = 20,
    parameter int unsigned T_WR_PULSE    = 40,
    parameter int unsigned T_WR_CYC      = 55,
    parameter int unsigned T_DATA_SETUP  = 25,
    parameter int unsigned T_ADDR_TO_END = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W/8-1:0]     req_mask,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [DATA_W/8-1:0]     mem_be_n,
    output logic [DATA_W-1:0]       mem_dq_out,
    output logic                    mem_dq_drive,
    input  logic [DATA_W-1:0]       mem_dq_in
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned P       = CLK_PERIOD_NS;
    localparam int unsigned RD_LEN  = max2(max2(ns_to_cycles(T_ADDR_ACC, P),
                                                ns_to_cycles(T_OE_ACC, P)),
                                           ns_to_cycles(T_READ_CYC, P));
    localparam int unsigned REL_LEN = ns_to_cycles(T_BUS_REL, P);
    localparam int unsigned WR_LEN  = max2(max2(ns_to_cycles(T_WR_PULSE, P),
                                                ns_to_cycles(T_ADDR_TO_END, P)),
                                           max2(ns_to_cycles(T_DATA_SETUP, P),
                                                ns_to_cycles(T_WR_CYC, P) - 1));
    localparam int unsigned LONGEST = max2(max2(RD_LEN, WR_LEN), REL_LEN);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    ctrl_state_e state, next_state;

    logic [ADDR_W-1:0]  op_addr;
    logic [DATA_W-1:0]  op_wdata;
    logic [LANES-1:0]   op_mask;
    logic               accept;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_done;
    logic               capture;
    logic               strobe_on;

    assign accept   = req_valid && (state == ST_IDLE);
    assign capture  = (state == ST_RD_ACCESS) && tmr_done;
    assign tmr_load = accept || capture;
    assign tmr_val  = accept ? (req_write ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1))
                             : CNT_W'(REL_LEN - 1);

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_lane_gate #(.LANES(LANES), .LANE_W(8)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_sel  (op_mask),
        .strobe_on (strobe_on),
        .lane_en_n (mem_be_n),
        .bus_in    (mem_dq_in),
        .capture   (capture),
        .captured  (rsp_rdata)
    );

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_addr   <= '0;
            op_wdata  <= '0;
            op_mask   <= '0;
            rsp_valid <= 1'b0;
        end else begin
            state     <= next_state;
            rsp_valid <= capture || ((state == ST_WR_STROBE) && tmr_done);
            if (accept) begin
                op_addr  <= req_addr;
                op_wdata <= req_wdata;
                op_mask  <= req_mask;
            end
        end
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:       if (req_valid) next_state = req_write ? ST_WR_STROBE : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_done)  next_state = ST_RD_RELEASE;
            ST_RD_RELEASE: if (tmr_done)  next_state = ST_IDLE;
            ST_WR_STROBE:  if (tmr_done)  next_state = ST_WR_HOLD;
            ST_WR_HOLD:                   next_state = ST_IDLE;
            default:                      next_state = ST_IDLE;
        endcase
    end

    // Pin decode
    always_comb begin
        req_ready    = 1'b0;
        mem_ce_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_we_n     = 1'b1;
        strobe_on    = 1'b0;
        mem_dq_drive = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_RD_ACCESS: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = 1'b0;
                strobe_on = 1'b1;
            end
            ST_RD_RELEASE: ;
            ST_WR_STROBE: begin
                mem_ce_n     = 1'b0;
                mem_we_n     = 1'b0;
                strobe_on    = 1'b1;
                mem_dq_drive = 1'b1;
            end
            ST_WR_HOLD:    mem_dq_drive = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr   = op_addr;
    assign mem_dq_out = op_wdata;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned REL_LEN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drive
);
    logic [7:0] since_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_oe <= 8'hFF;
        else if (!mem_oe_n)
            since_oe <= 8'd0;
        else if (since_oe != 8'hFF)
            since_oe <= since_oe + 8'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_drive)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_drive) |-> (int'(since_oe) >= int'(REL_LEN))); // R4

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out)); // R6

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_drive && mem_we_n)); // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REL_LEN (REL_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_addr     (mem_addr),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int PER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_drive;
    logic [15:0] mem_dq_in = 16'hA5A5;

    always #(PER/2) clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    function automatic int cdiv(int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    int n_rd, n_rel, n_wr;
    initial begin
        n_rd  = imax(imax(cdiv(55), cdiv(30)), cdiv(55));
        n_rel = cdiv(20);
        n_wr  = imax(imax(cdiv(40), cdiv(50)), imax(cdiv(25), cdiv(55) - 1));
    end

    typedef struct {
        bit        rdy;
        bit        ce_n, oe_n, we_n;
        bit [1:0]  be_n;
        bit        drv;
        bit        rsp;
        bit        chk_rd;
        bit [17:0] addr;
        bit [15:0] dq;
        bit [15:0] rd;
        string     tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] mem[int];
    int          vectors = 0;
    int          fails = 0;
    bit          acc_flag = 0;

    function automatic logic [15:0] mem_get(logic [17:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {a[15:8] ^ 8'hC3, a[7:0] ^ 8'h3C};
    endfunction

    function automatic exp_t idle_exp(string tag);
        exp_t e;
        e.rdy = 1; e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.be_n = 2'b11;
        e.drv = 0; e.rsp = 0; e.chk_rd = 0; e.addr = '0; e.dq = '0; e.rd = '0;
        e.tag = tag;
        return e;
    endfunction

    task automatic push_seq(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
        exp_t e;
        logic [15:0] w;
        string t;
        w = mem_get(a);
        if (!wr) begin
            for (int i = 0; i < n_rd; i++) begin
                e = idle_exp(m == 2'b00 ? "R9" : "R2");
                e.rdy = 0; e.ce_n = 0; e.oe_n = 0; e.be_n = ~m; e.addr = a;
                expq.push_back(e);
            end
            for (int i = 0; i < n_rel; i++) begin
                e = idle_exp("R4");
                e.rdy = 0;
                if (i == 0) begin
                    e.rsp = 1; e.chk_rd = 1;
                    e.rd = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
                end
                expq.push_back(e);
            end
        end else begin
            t = (m == 2'b00) ? "R9" : "R5";
            for (int i = 0; i < n_wr; i++) begin
                e = idle_exp(t);
                e.rdy = 0; e.ce_n = 0; e.we_n = 0; e.be_n = ~m; e.addr = a;
                e.drv = 1; e.dq = d;
                expq.push_back(e);
            end
            e = idle_exp("R6");
            e.rdy = 0; e.drv = 1; e.dq = d; e.rsp = 1;
            expq.push_back(e);
        end
    endtask

    // RAM behaviour: counts elapsed access time and checks write widths
    int          rd_cnt = 0;
    int          w_cnt = 0;
    int          d_cnt = 0;
    logic [15:0] w_data;
    logic [1:0]  w_be_n;
    logic [17:0] w_addr;

    task automatic ram_model();
        logic [15:0] w;
        if (!mem_ce_n && !mem_we_n) begin
            if (w_cnt > 0 && mem_dq_drive && mem_dq_out == w_data) d_cnt++;
            else d_cnt = mem_dq_drive ? 1 : 0;
            w_cnt++;
            w_data = mem_dq_out; w_be_n = mem_be_n; w_addr = mem_addr;
        end else if (w_cnt > 0) begin
            vectors++;
            if (w_cnt * PER < 50 || d_cnt * PER < 25) begin
                fails++;
                $display("FAIL R5 write widths: got pulse %0d ns data %0d ns, expected >= 50 ns and >= 25 ns",
                         w_cnt * PER, d_cnt * PER);
            end
            w = mem_get(w_addr);
            if (!w_be_n[0]) w[7:0]  = w_data[7:0];
            if (!w_be_n[1]) w[15:8] = w_data[15:8];
            if (w_be_n != 2'b11) mem[int'(w_addr)] = w;
            w_cnt = 0; d_cnt = 0;
        end
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++;
        else rd_cnt = 0;
        if (rd_cnt > 0 && rd_cnt * PER >= 55) begin
            w = mem_get(mem_addr);
            mem_dq_in = {mem_be_n[1] ? 8'h5A : w[15:8], mem_be_n[0] ? 8'h5A : w[7:0]};
        end else begin
            mem_dq_in = 16'hA5A5;
        end
    endtask

    task automatic compare(exp_t e);
        bit bad;
        string t;
        vectors++;
        bad = 0;
        t = e.tag;
        if (req_ready !== e.rdy) begin bad = 1; if (e.tag != "R1") t = "R7"; end
        if (mem_ce_n !== e.ce_n || mem_oe_n !== e.oe_n || mem_we_n !== e.we_n ||
            mem_be_n !== e.be_n || mem_dq_drive !== e.drv) bad = 1;
        if (!e.ce_n && mem_addr !== e.addr) bad = 1;
        if (e.drv && mem_dq_out !== e.dq) bad = 1;
        if (rsp_valid !== e.rsp || (e.chk_rd && rsp_rdata !== e.rd)) begin bad = 1; t = "R3"; end
        if (bad) begin
            fails++;
            $display("FAIL %s: got rdy%b ce%b oe%b we%b be%b drv%b rsp%b addr%h dq%h rd%h, expected rdy%b ce%b oe%b we%b be%b drv%b rsp%b addr%h dq%h rd%h",
                     t, req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_drive,
                     rsp_valid, mem_addr, mem_dq_out, rsp_rdata,
                     e.rdy, e.ce_n, e.oe_n, e.we_n, e.be_n, e.drv, e.rsp, e.addr, e.dq, e.rd);
        end
    endtask

    always @(negedge clk) begin
        ram_model();
        if (expq.size() > 0) begin
            compare(expq.pop_front());
        end else begin
            compare(idle_exp("R1"));
            if (rst_n && req_valid) begin
                push_seq(req_write, req_addr, req_wdata, req_mask);
                acc_flag = 1;
            end
        end
    end

    // Caller stands 1 ns after a rising edge; returns 1 ns after the taking edge.
    task automatic issue(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1;
        forever begin
            @(posedge clk);
            if (acc_flag) break;
        end
        #1;
        acc_flag = 0;
        req_valid = 0;
    endtask

    task automatic gap(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no end of test, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);   // R1 reset state compared every cycle
        #1;
        rst_n = 1;
        gap(2);
        issue(0, 18'h00123, 16'h0000, 2'b11);   // R2 R3 unwritten word
        gap(3);
        issue(1, 18'h00005, 16'hBEEF, 2'b11);   // R5 R6
        issue(0, 18'h00005, 16'h0000, 2'b11);   // R7 held valid during write
        issue(1, 18'h00005, 16'h1234, 2'b01);   // R5 lower lane only
        issue(0, 18'h00005, 16'h0000, 2'b11);
        issue(1, 18'h00005, 16'hABCD, 2'b10);   // upper lane only
        issue(0, 18'h00005, 16'h0000, 2'b01);   // R3 upper masked to zero
        issue(0, 18'h00005, 16'h0000, 2'b10);   // R3 lower masked to zero
        issue(1, 18'h00005, 16'hFFFF, 2'b00);   // R9 no lane written
        issue(0, 18'h00005, 16'h0000, 2'b11);   // R9 readback unchanged
        issue(0, 18'h00005, 16'h0000, 2'b00);   // R9 read returns zero
        issue(0, 18'h3FFFF, 16'h0000, 2'b11);   // R4 read then write turnaround
        issue(1, 18'h3FFFF, 16'h5AA5, 2'b11);   // R8 drive only after release
        issue(0, 18'h3FFFF, 16'h0000, 2'b11);
        issue(1, 18'h00000, 16'h0F0F, 2'b11);
        issue(1, 18'h00001, 16'hF0F0, 2'b11);   // R7 write after write
        issue(0, 18'h00000, 16'h0000, 2'b11);
        issue(0, 18'h00001, 16'h0000, 2'b11);   // R7 read after read
        gap(15);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule